// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves like a byte-addressable non-volatile memory. A register array stands in for the storage cells. The block runs from a fast system clock that oversamples both bus lines. Start and stop conditions and clock edges are recovered inside the block. The bidirectional data line is handled as open-drain: there is one input, one constant-low drive value and one output enable.

A master opens a transaction with a device address byte. That byte carries the fixed type code 1010, the three strap bits and a direction bit. For a write, the master then sends a high and a low word address byte, followed by one or more data bytes. Data bytes advance within a single page. For a read, bytes stream out of the current address and advance across the whole array.

A protect input blocks writes to the top quarter of the array. After each write, a busy window opens, and during it the slave ignores its own address. The array is sized by `ADDR_W`. The full 8 KB part, with 256 pages of 32 bytes, is `ADDR_W = 13`. The default of 11 keeps elaboration small.

Top module: `twi_ee_slave`

## Requirements
- R1: After reset the slave leaves SDA released (`sda_oe` = 0), is not busy, and acknowledges a matching device address at once.
- R2: A device address byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `dev_sel`. Bit 0 = 1 selects a read. On a mismatch the ninth clock sees SDA high and the slave stays silent until the next start.
- R3: A write of one data byte at a word address is later returned by a read of that same address.
- R4: During a multi-byte write, the address advances within the current 32-byte page. After offset 31 it returns to offset 0 of the same page. The neighbouring pages are untouched.
- R5: During a read, each master acknowledge (SDA low on the ninth clock) makes the slave send the next byte. After the last address, the next byte comes from address 0.
- R6: A current-address read returns the byte at the last accessed address plus one. For a write, "plus one" follows the page wrap of R4. For a read, it follows the array wrap of R5.
- R7: While `wp_in` is 1, data bytes aimed at the top quarter of the array (both upper address bits 1) are acknowledged but not stored. Bytes aimed at lower addresses are stored. While `wp_in` is 0, all addresses are writable.
- R8: A stop, or a repeated start, that ends a write containing at least one data byte opens a busy window of `BUSY_CYCLES` clocks. During that window the device address is not acknowledged and SDA is never pulled low.
- R9: A start condition, which is SDA falling while SCL is high, aborts any transaction in progress. The next byte is then taken as a device address.
- R10: A master no-acknowledge on the ninth clock of a read byte ends the read, and SDA is released before the stop.
- R11: Word address bits above `ADDR_W-1` are ignored.
- R12: The slave only ever pulls SDA low, and it changes its drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_out | output | 1 | Value driven on SDA when enabled, always 0 |
| sda_oe | output | 1 | Enable of the SDA pull-down |
| dev_sel | input | 3 | Strap bits matched against device address bits 3:1 |
| wp_in | input | 1 | Write protect of the top quarter, tie low if unused |

## Verification
The assertions check the following on every cycle:
- the busy window never pulls SDA low;
- the SDA drive never changes while SCL is high;
- a stored data byte never advances the pointer out of its page;
- each byte loaded for a read steps the pointer by exactly one;
- no byte is committed to the protected quarter while `wp_in` is high.

Only the bench's bus transactions can show the end-to-end results. These are what the array holds after page wraps, array wraps and blocked writes; what a current-address read returns; acknowledge versus no-acknowledge on address mismatch and during busy; and recovery from an aborted transaction.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} bus_st_e;
  typedef enum logic [1:0] {PH_DEV, PH_AHI, PH_ALO, PH_DATA} rx_ph_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_ff[SYNC_STAGES-1];
      sda_p <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_ee_busy.sv
module twi_ee_busy #(
  parameter int BUSY_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (kick)             cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave import twi_ee_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_out,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wp_in
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, kick, wr_req, rd_load, prot_hit, mem_we;
  logic [7:0] rdata;

  bus_st_e st_q, st_d, to_q, to_d;
  rx_ph_e  ph_q, ph_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d, ahi_q, ahi_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ack_q, ack_d, mok_q, mok_d, pend_q, pend_d;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_ee_busy #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );

  assign prot_hit = wp_in && (ptr_q[ADDR_W-1 -: 2] == 2'b11);
  assign mem_we   = wr_req && !prot_hit;

  twi_ee_store #(.ADDR_W(ADDR_W)) i_store (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(sh_q),
    .raddr(ptr_q), .rdata(rdata)
  );

  always_comb begin
    st_d = st_q; ph_d = ph_q; cnt_d = cnt_q; sh_d = sh_q; ptr_d = ptr_q;
    ahi_d = ahi_q; ack_d = ack_q; to_d = to_q; mok_d = mok_q; pend_d = pend_q;
    wr_req = 1'b0; rd_load = 1'b0; kick = 1'b0;
    if (start_det) begin
      st_d = S_RX; ph_d = PH_DEV; cnt_d = '0; pend_d = 1'b0; kick = pend_q;
    end else if (stop_det) begin
      st_d = S_IDLE; pend_d = 1'b0; kick = pend_q;
    end else begin
      case (st_q)
        S_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_d = S_ACK; cnt_d = '0; ack_d = 1'b1; to_d = S_RX;
            case (ph_q)
              PH_DEV: begin
                if (sh_q[7:4] == DEV_TYPE && sh_q[3:1] == dev_sel && !busy) begin
                  to_d = sh_q[0] ? S_TX : S_RX;
                  ph_d = PH_AHI;
                end else begin
                  ack_d = 1'b0;
                  to_d  = S_IDLE;
                end
              end
              PH_AHI: begin ahi_d = sh_q; ph_d = PH_ALO; end
              PH_ALO: begin ptr_d = ADDR_W'({ahi_q, sh_q}); ph_d = PH_DATA; end
              default: begin
                wr_req = 1'b1;
                pend_d = 1'b1;
                ptr_d  = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            st_d = to_q; cnt_d = '0;
            if (to_q == S_TX) rd_load = 1'b1;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_d = S_MACK; cnt_d = '0;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; cnt_d = cnt_q + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mok_d = !sda_s;
          if (scl_fall) begin
            if (mok_q) begin rd_load = 1'b1; st_d = S_TX; end
            else       st_d = S_IDLE;
          end
        end
        default: ;
      endcase
      if (rd_load) begin
        sh_d  = rdata;
        ptr_d = ptr_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ph_q <= PH_DEV; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      ahi_q <= '0; ack_q <= 1'b0; to_q <= S_IDLE; mok_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d; ptr_q <= ptr_d;
      ahi_q <= ahi_d; ack_q <= ack_d; to_q <= to_d; mok_q <= mok_d; pend_q <= pend_d;
    end
  end

  assign sda_out = 1'b0;
  assign sda_oe  = (st_q == S_ACK && ack_q) || (st_q == S_TX && !sh_q[7]);
endmodule

// File: rtl/twi_ee_slave_chk.sv
module twi_ee_slave_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic              busy,
  input logic              wp_in,
  input logic [ADDR_W-1:0] ptr,
  input logic              wr_req,
  input logic              mem_we,
  input logic              rd_load
);
  p_busy_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ptr == $past(ptr) + ADDR_W'(1));

  p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(wp_in && ptr[ADDR_W-1 -: 2] == 2'b11));
endmodule

bind twi_ee_slave twi_ee_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .busy(busy),
  .wp_in(wp_in), .ptr(ptr_q), .wr_req(wr_req), .mem_we(mem_we), .rd_load(rd_load)
);

// File: tb/test_twi_ee_slave.sv
`timescale 1ns/1ps
module test_twi_ee_slave;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_out, sda_oe, sda_line;
  int total = 0, bad = 0, cur = 0, cyc = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  assign sda_line = sda_m & ~(sda_oe & ~sda_out);

  twi_ee_slave #(.ADDR_W(AW)) i_twi_ee_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_out(sda_out), .sda_oe(sda_oe), .dev_sel(pins), .wp_in(wp)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string r, input int act, input int expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  // scoreboard monitor: compares each received byte with the queued expectation
  initial forever begin
    @(posedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic d, output logic s);
    logic s2;
    sda_m = d; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); s2 = sda_line;
    if (s !== s2) chk("R12 sda stable while scl high", s2, s);
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(!mack, s);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, pins, rw};
  endfunction

  task automatic wait_idle();
    logic ack;
    for (int n = 0; n < 40; n++) begin
      bus_start(); send_byte(dev(1'b0), ack); bus_stop();
      if (ack) break;
    end
  endtask

  task automatic write_seq(input logic [15:0] a16, input int n, input logic [7:0] seed, input string r);
    logic ack;
    int a;
    a = a16 & (DEPTH - 1);
    bus_start();
    send_byte(dev(1'b0), ack); chk({r, " dev ack"}, ack, 1);
    send_byte(a16[15:8], ack);
    send_byte(a16[7:0], ack);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      int wa;
      d = seed + 8'(i * 7);
      wa = (a & ~31) | ((a + i) & 31);
      send_byte(d, ack); chk({r, " data ack"}, ack, 1);
      if (!(wp && wa >= (DEPTH * 3) / 4)) model[wa] = d;
    end
    cur = (a & ~31) | ((a + n) & 31);
    bus_stop();
  endtask

  task automatic read_bytes(input int n, input string r);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(cur + i) % DEPTH]); tag_q.push_back(r);
      recv_byte(i < n - 1, b);
      got_q.push_back(b);
    end
    cur = (cur + n) % DEPTH;
    wq();
    chk("R10 sda released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic read_rand(input logic [15:0] a16, input int n, input string r);
    logic ack;
    bus_start();
    send_byte(dev(1'b0), ack); chk({r, " dev ack"}, ack, 1);
    send_byte(a16[15:8], ack);
    send_byte(a16[7:0], ack);
    cur = a16 & (DEPTH - 1);
    bus_start();
    send_byte(dev(1'b1), ack); chk({r, " read dev ack"}, ack, 1);
    read_bytes(n, r);
  endtask

  task automatic read_cur(input int n, input string r);
    logic ack;
    bus_start();
    send_byte(dev(1'b1), ack); chk({r, " cur dev ack"}, ack, 1);
    read_bytes(n, r);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 200000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R1 sda released at reset", sda_oe, 0);
    bus_start(); send_byte(dev(1'b0), ack); bus_stop();
    chk("R1 first address acked", ack, 1);

    // R2: wrong strap bits, wrong type code
    bus_start(); send_byte({4'b1010, 3'b000, 1'b0}, ack); bus_stop();
    chk("R2 strap mismatch nack", ack, 0);
    bus_start(); send_byte({4'b1011, pins, 1'b1}, ack); bus_stop();
    chk("R2 type mismatch nack", ack, 0);
    chk("R2 silent after mismatch", sda_oe, 0);

    // R3 and R8
    write_seq(16'h0123, 1, 8'hA5, "R3");
    bus_start(); send_byte(dev(1'b0), ack); bus_stop();
    chk("R8 busy nack after write", ack, 0);
    wait_idle();
    read_rand(16'h0123, 1, "R3");

    // R6 current-address read after random read
    write_seq(16'h0040, 3, 8'h10, "R6"); wait_idle();
    read_rand(16'h0040, 1, "R6");
    read_cur(2, "R6");

    // R4 page wrap
    write_seq(16'h0080, 1, 8'h3C, "R4"); wait_idle();
    write_seq(16'h007E, 4, 8'h50, "R4"); wait_idle();
    read_rand(16'h007E, 2, "R4");
    read_rand(16'h0060, 2, "R4");
    read_rand(16'h0080, 1, "R4");

    // R5 array wrap on sequential read
    write_seq(16'h07FE, 2, 8'h90, "R5"); wait_idle();
    write_seq(16'h0000, 1, 8'hC1, "R5"); wait_idle();
    read_rand(16'h07FE, 3, "R5");
    read_cur(1, "R6");

    // R11 ignored upper address bits
    write_seq(16'hF910, 1, 8'h6B, "R11"); wait_idle();
    read_rand(16'h0110, 1, "R11");

    // R7 write protect
    write_seq(16'h0700, 1, 8'h22, "R7"); wait_idle();
    wp = 1'b1;
    write_seq(16'h0700, 1, 8'h11, "R7"); wait_idle();
    write_seq(16'h0200, 1, 8'h33, "R7"); wait_idle();
    read_rand(16'h0700, 1, "R7");
    read_rand(16'h0200, 1, "R7");
    wp = 1'b0;
    write_seq(16'h0700, 1, 8'h44, "R7"); wait_idle();
    read_rand(16'h0700, 1, "R7");

    // R9 aborted transaction then fresh random read
    bus_start(); send_byte(dev(1'b0), ack); send_byte(8'h01, ack);
    read_rand(16'h0123, 1, "R9");

    repeat (20) @(posedge clk);
    #1;
    chk("R9 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule